// File: doc/BRIEF.md
# Standby GPIO Controller with Interrupt Window

The block is a memory-mapped general-purpose I/O controller on a simple 32-bit register bus. Software sets a direction per pin, the value driven on each output pin, and reads back the synchronized level of every pin. A contiguous window of pins can also be turned into dedicated interrupt lines toward a parent interrupt controller. Each routed line has its own polarity bit. Whatever level the pin is active at, the parent always receives an active-high request.

A bus access is a single-cycle request. A write takes effect on the clock edge that accepts it. Read data is registered and appears on `rdata_o` one cycle after the request, where it stays until the next read. The pad side has separate output-enable and output-data pins, and an input per pin that the pad cell feeds back.

Top module: `sb_gpio_irq`

## Requirements
- R1: After reset, every register reads 0, `pad_oe_o` and `pad_out_o` are 0, and `irq_o` is 0.
- R2: Bit n of the direction register (offset 0x29C) and of the output-data register (offset 0x2A0) belongs to pin n. `pad_oe_o` equals the direction register. `pad_out_o` carries the output-data bit only where direction is 1, and 0 elsewhere. Both registers read back what was written.
- R3: The input register (offset 0x2A4) shows, at bit n, the level of `pad_i[n]` after a two-flop synchronizer, whatever the direction setting. A read issued two or more cycles after a pad change returns the new level.
- R4: Interrupt line k (k = 0..5) comes from pin 8+k. Its polarity is set by bit k of the polarity register (offset 0x290), indexed by the line number and not by the pin number.
- R5: A polarity bit of 1 raises `irq_o[k]` while the pin is high. A polarity bit of 0 raises it while the pin is low. `irq_o` is active high in both cases.
- R6: Bit 2g of the select register (offset 0x294) routes pin g (g = 8..13) to its interrupt line. While that bit is 0, the line stays low whatever the pin level.
- R7: Writes to any offset other than 0x290, 0x294, 0x29C and 0x2A0 change no register. This includes writes to the read-only input offset. Reads of unmapped offsets return 0.
- R8: Bits above pin 21 in the direction, output and input registers, bits above line 5 in the polarity register, and every select bit other than 2g for g = 8..13, read 0 and cannot be set.
- R9: Read data appears on `rdata_o` in the cycle after the read request and holds until the next read.
- R10: A pad change reaches `irq_o` on the third rising edge after it. A change to a select or polarity bit reaches `irq_o` on the edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus request, one cycle per access |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | 12 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| pad_i | input | 22 | Pad levels from the pins |
| pad_oe_o | output | 22 | Per-pin output enable |
| pad_out_o | output | 22 | Per-pin driven value, masked by enable |
| irq_o | output | 6 | Active-high requests to the parent controller |

## Verification
The hardest case to reach is a mix of polarities across the window. A fault that indexes polarity by pin number, or that swaps the sense of one line, shows up only when neighbouring lines use different polarities and see different pad levels. The stimulus drives every window pin high with only line 0 set active-high, and then drives all pins low under an alternating polarity pattern, so that each line must resolve its own bit. Latency is checked on exact cycles: the bench changes a pad on a falling edge and samples `irq_o` on the second and third falling edges after that.

// File: rtl/sbg_pkg.sv
package sbg_pkg;
  localparam int DW = 32;
  localparam int AW = 12;

  localparam logic [AW-1:0] OFS_POL = 12'h290;
  localparam logic [AW-1:0] OFS_SEL = 12'h294;
  localparam logic [AW-1:0] OFS_OE  = 12'h29C;
  localparam logic [AW-1:0] OFS_OUT = 12'h2A0;
  localparam logic [AW-1:0] OFS_IN  = 12'h2A4;

  typedef enum logic [2:0] {
    RS_NONE, RS_POL, RS_SEL, RS_OE, RS_OUT, RS_IN
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(logic [AW-1:0] a);
    case (a)
      OFS_POL: return RS_POL;
      OFS_SEL: return RS_SEL;
      OFS_OE:  return RS_OE;
      OFS_OUT: return RS_OUT;
      OFS_IN:  return RS_IN;
      default: return RS_NONE;
    endcase
  endfunction

  function automatic logic [DW-1:0] low_mask(int n);
    logic [DW-1:0] m;
    m = '0;
    for (int i = 0; i < DW; i++) if (i < n) m[i] = 1'b1;
    return m;
  endfunction

  // one enable bit per window pin, at bit 2*pin
  function automatic logic [DW-1:0] sel_mask(int base, int n);
    logic [DW-1:0] m;
    m = '0;
    for (int i = 0; i < DW / 2; i++) if (i >= base && i < base + n) m[2*i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/sbg_sync.sv
module sbg_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;

  a_r3_two_stage: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> sync_q == $past(meta_q));
endmodule

// File: rtl/sbg_regs.sv
module sbg_regs
  import sbg_pkg::*;
#(
  parameter int NUM_PINS = 22,
  parameter int IRQ_BASE = 8,
  parameter int NUM_IRQ  = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [DW-1:0]       wdata_i,
  input  logic [NUM_PINS-1:0] din_i,
  output logic [DW-1:0]       rdata_o,
  output logic [NUM_PINS-1:0] oe_o,
  output logic [NUM_PINS-1:0] dout_o,
  output logic [NUM_IRQ-1:0]  pol_o,
  output logic [NUM_IRQ-1:0]  sel_o
);
  localparam logic [DW-1:0] PIN_MASK = low_mask(NUM_PINS);
  localparam logic [DW-1:0] POL_MASK = low_mask(NUM_IRQ);
  localparam logic [DW-1:0] SEL_MASK = sel_mask(IRQ_BASE, NUM_IRQ);

  logic [DW-1:0] oe_q, out_q, pol_q, sel_q, rdata_q, rd_mux, din_w;
  reg_sel_e      rs;
  logic          wr, rd;

  assign rs    = decode_addr(addr_i);
  assign wr    = req_i & we_i;
  assign rd    = req_i & ~we_i;
  assign din_w = DW'(din_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q  <= '0;
      out_q <= '0;
      pol_q <= '0;
      sel_q <= '0;
    end else if (wr) begin
      case (rs)
        RS_OE:   oe_q  <= wdata_i & PIN_MASK;
        RS_OUT:  out_q <= wdata_i & PIN_MASK;
        RS_POL:  pol_q <= wdata_i & POL_MASK;
        RS_SEL:  sel_q <= wdata_i & SEL_MASK;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rs)
      RS_OE:   rd_mux = oe_q;
      RS_OUT:  rd_mux = out_q;
      RS_POL:  rd_mux = pol_q;
      RS_SEL:  rd_mux = sel_q;
      RS_IN:   rd_mux = din_w;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
  assign oe_o    = oe_q[NUM_PINS-1:0];
  assign dout_o  = out_q[NUM_PINS-1:0];
  assign pol_o   = pol_q[NUM_IRQ-1:0];

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_sel
    assign sel_o[k] = sel_q[2*(IRQ_BASE+k)];
  end

  a_r2_oe_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && rs == RS_OE) |=> oe_q == ($past(wdata_i) & PIN_MASK));
  a_r7_unmapped_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && (rs == RS_NONE || rs == RS_IN)) |=>
      ($stable(oe_q) && $stable(out_q) && $stable(pol_q) && $stable(sel_q)));
  a_r7_unmapped_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && rs == RS_NONE) |=> rdata_o == '0);
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(rdata_o));
endmodule

// File: rtl/sbg_irq_map.sv
module sbg_irq_map #(
  parameter int NUM_IRQ = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] lvl_i,
  input  logic [NUM_IRQ-1:0] pol_i,
  input  logic [NUM_IRQ-1:0] sel_i,
  output logic [NUM_IRQ-1:0] irq_o
);
  logic [NUM_IRQ-1:0] irq_q;

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_line
    // polarity 1: active high; 0: active low
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_q[k] <= 1'b0;
      else         irq_q[k] <= sel_i[k] & (lvl_i[k] ~^ pol_i[k]);
    end

    a_r6_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sel_i[k] |=> !irq_o[k]);
    a_r5_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i[k] && lvl_i[k] == pol_i[k]) |=> irq_o[k]);
    a_r5_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lvl_i[k] != pol_i[k]) |=> !irq_o[k]);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/sb_gpio_irq.sv
module sb_gpio_irq
  import sbg_pkg::*;
#(
  parameter int NUM_PINS = 22,
  parameter int IRQ_BASE = 8,
  parameter int NUM_IRQ  = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [11:0]         addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  input  logic [NUM_PINS-1:0] pad_i,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_IRQ-1:0]  irq_o
);
  logic [NUM_PINS-1:0] din_s, oe, dout;
  logic [NUM_IRQ-1:0]  pol, sel;

  sbg_sync #(.W(NUM_PINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_i),
    .q_o    (din_s)
  );

  sbg_regs #(.NUM_PINS(NUM_PINS), .IRQ_BASE(IRQ_BASE), .NUM_IRQ(NUM_IRQ)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .din_i   (din_s),
    .rdata_o (rdata_o),
    .oe_o    (oe),
    .dout_o  (dout),
    .pol_o   (pol),
    .sel_o   (sel)
  );

  sbg_irq_map #(.NUM_IRQ(NUM_IRQ)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (din_s[IRQ_BASE +: NUM_IRQ]),
    .pol_i  (pol),
    .sel_i  (sel),
    .irq_o  (irq_o)
  );

  assign pad_oe_o  = oe;
  assign pad_out_o = dout & oe;

  a_r2_no_drive_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_out_o & ~pad_oe_o) == '0);
endmodule

// File: tb/sb_gpio_irq_tb.sv
`timescale 1ns/1ps
module sb_gpio_irq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [21:0] pad = '0;
  logic [21:0] pad_oe, pad_out;
  logic [5:0]  irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sb_gpio_irq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pad_i(pad), .pad_oe_o(pad_oe),
    .pad_out_o(pad_out), .irq_o(irq)
  );

  localparam logic [11:0] A_POL = 12'h290, A_SEL = 12'h294, A_OE = 12'h29C,
                          A_OUT = 12'h2A0, A_IN = 12'h2A4;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0; d = rdata;
  endtask

  task automatic rd_chk(string tag, logic [11:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(tag, d, exp);
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rd_chk("R1 pol", A_POL, 0);
    rd_chk("R1 sel", A_SEL, 0);
    rd_chk("R1 oe", A_OE, 0);
    rd_chk("R1 out", A_OUT, 0);
    rd_chk("R1 in", A_IN, 0);
    check("R1 pad_oe", 32'(pad_oe), 0);
    check("R1 pad_out", 32'(pad_out), 0);
    check("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_gpio_out;
    wr(A_OE, 32'h0000F0F0);
    wr(A_OUT, 32'h003FFFFF);
    rd_chk("R2 out readback", A_OUT, 32'h003FFFFF);
    rd_chk("R2 oe readback", A_OE, 32'h0000F0F0);
    check("R2 pad_oe", 32'(pad_oe), 32'h0000F0F0);
    check("R2 pad_out masked", 32'(pad_out), 32'h0000F0F0);
    wr(A_OUT, 32'h00001234);
    check("R2 pad_out data", 32'(pad_out), 32'h00001030);
    wr(A_OE, 0);
    check("R2 pad_out off", 32'(pad_out), 0);
  endtask

  task automatic t_input;
    @(negedge clk); pad = 22'h2A5A5A;
    wait_cyc(2);
    rd_chk("R3 in level", A_IN, 32'h002A5A5A);
    wr(A_OE, 32'h003FFFFF);
    @(negedge clk); pad = 22'h15A5A5;
    wait_cyc(2);
    rd_chk("R3 in with oe set", A_IN, 32'h0015A5A5);
    wr(A_OE, 0);
    pad = '0;
    wait_cyc(3);
  endtask

  task automatic t_upper;
    wr(A_OE, 32'hFFFFFFFF);
    rd_chk("R8 oe upper", A_OE, 32'h003FFFFF);
    wr(A_OUT, 32'hFFFFFFFF);
    rd_chk("R8 out upper", A_OUT, 32'h003FFFFF);
    wr(A_POL, 32'hFFFFFFFF);
    rd_chk("R8 pol upper", A_POL, 32'h0000003F);
    wr(A_SEL, 32'hFFFFFFFF);
    rd_chk("R8 sel window only", A_SEL, 32'h05550000);
    wr(A_OE, 0); wr(A_OUT, 0); wr(A_POL, 0); wr(A_SEL, 0);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    wr(A_OE, 32'h00000055);
    wr(A_POL, 32'h00000009);
    wr(A_SEL, 32'h00010000);
    wr(A_OUT, 32'h00000011);
    wr(12'h298, 32'hFFFFFFFF);
    wr(12'h2A8, 32'hFFFFFFFF);
    wr(12'h000, 32'hFFFFFFFF);
    wr(A_IN, 32'hFFFFFFFF);
    rd_chk("R7 oe kept", A_OE, 32'h00000055);
    rd_chk("R7 pol kept", A_POL, 32'h00000009);
    rd_chk("R7 sel kept", A_SEL, 32'h00010000);
    rd_chk("R7 out kept", A_OUT, 32'h00000011);
    rd_chk("R7 in unaffected", A_IN, 0);
    rd_chk("R7 read 0x298", 12'h298, 0);
    rd_chk("R7 read 0x000", 12'h000, 0);
    rd(A_OE, d);
    wait_cyc(2);
    check("R9 rdata held", rdata, 32'h00000055);
    wr(A_OE, 0); wr(A_POL, 0); wr(A_SEL, 0); wr(A_OUT, 0);
  endtask

  task automatic t_map;
    wr(A_POL, 32'h3F);
    wr(A_SEL, 32'h05550000);
    wait_cyc(4);
    check("R4 idle", 32'(irq), 0);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); pad = 22'(1) << (8 + k);
      wait_cyc(3);
      check($sformatf("R4 pin %0d to line %0d", 8 + k, k), 32'(irq), 32'(1) << k);
    end
    @(negedge clk); pad = 22'h20_4080 | 22'h00C07F;
    wait_cyc(3);
    check("R4 pins outside window", 32'(irq), 0);
    pad = '0;
    wait_cyc(3);
  endtask

  task automatic t_polarity;
    wr(A_POL, 0);
    wait_cyc(1);
    check("R5 active low idle pins", 32'(irq), 32'h3F);
    @(negedge clk); pad = 22'h003F00;
    wait_cyc(3);
    check("R5 active low pins high", 32'(irq), 0);
    wr(A_POL, 32'h01);
    wait_cyc(1);
    check("R5 polarity by line index", 32'(irq), 32'h01);
    @(negedge clk); pad = '0;
    wr(A_POL, 32'h15);
    wait_cyc(3);
    check("R5 mixed polarity", 32'(irq), 32'h2A);
  endtask

  task automatic t_select;
    wr(A_POL, 32'h3F);
    @(negedge clk); pad = 22'h003F00;
    wr(A_SEL, 32'h00100000);
    wait_cyc(3);
    check("R6 only pin 10 routed", 32'(irq), 32'h04);
    wr(A_SEL, 32'h0AAA0000);
    wait_cyc(1);
    check("R6 odd bits do not route", 32'(irq), 0);
    wr(A_SEL, 0);
    wait_cyc(1);
    check("R6 cleared select", 32'(irq), 0);
    pad = '0;
    wait_cyc(3);
  endtask

  task automatic t_latency;
    wr(A_POL, 32'h3F);
    wr(A_SEL, 32'h05550000);
    wait_cyc(1);
    @(negedge clk); pad = 22'(1) << 9;
    @(negedge clk);
    @(negedge clk);
    check("R10 irq not yet after 2 edges", 32'(irq), 0);
    @(negedge clk);
    check("R10 irq after 3 edges", 32'(irq), 32'h02);
    wr(A_SEL, 0);
    check("R10 select change not yet", 32'(irq), 32'h02);
    @(negedge clk);
    check("R10 select change applied", 32'(irq), 0);
    pad = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_gpio_out();
    t_input();
    t_upper();
    t_unmapped();
    t_map();
    t_polarity();
    t_select();
    t_latency();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule